// File: doc/BRIEF.md
# Branch Cycle and Queue Sequencer

This block drives the bus-cycle stream that a CPU with an instruction prefetch queue issues while it resolves a conditional branch. When the block is idle, a start strobe captures four things: the branch kind (short or long), the taken decision, whether the one-byte prefix that every long branch carries sits on an odd address, and the next sequential program address. The block then emits one cycle type per clock. The type is a program word fetch, a free cycle or idle. Every fetch comes with its address.

A short branch that is not taken makes a single sequential fetch. A long branch that is not taken issues three cycles: an optional cycle for the prefix, a sequential fetch, and a second optional cycle that keeps the queue topped up. Each optional cycle becomes a fetch when the prefix is odd-aligned and a free cycle when it is even-aligned. A taken branch waits in idle cycles until the destination address is reported ready. In that cycle it raises a queue-flush request. It then refills the queue with three consecutive word fetches from the destination. A long taken branch first spends its prefix optional cycle. A one-cycle done pulse closes every sequence.

Top module: `brq_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, cyc_type_o is idle (2'b00), fetch_addr_o is zero, and flush_o and done_o are low.
- R2: A short not-taken branch produces exactly one program fetch (2'b01), in the cycle after the start edge. Its address is seq_addr_i with bit 0 cleared.
- R3: A short taken branch produces idle cycles while tgt_ready_i is low. It then produces three program fetches at D, D+2 and D+4 (modulo 2^AW), where D is tgt_addr_i with bit 0 cleared, sampled in the flush cycle.
- R4: A long not-taken branch produces three non-idle cycles in the order optional, program fetch, optional.
- R5: An optional cycle is a program fetch when pre_odd_i was 1 at start and a free cycle (2'b10) when it was 0. Sequential fetches use consecutive word addresses starting at the aligned seq_addr_i. fetch_addr_o is zero on every cycle that is not a fetch.
- R6: A long taken branch produces one optional cycle, then idle cycles until tgt_ready_i, then the three-word refill of R3.
- R7: flush_o is high only in the cycle immediately before the first refill fetch of a taken branch, and only then.
- R8: done_o is a one-cycle pulse in the cycle after the last non-idle cycle of a sequence, with cyc_type_o idle.
- R9: A start strobe is ignored from the start edge up to and including the cycle in which done_o is high. No new sequence begins.
- R10: Branch kind, decision, prefix alignment and sequential address are captured at the start edge. Later changes to those inputs have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Branch start strobe, accepted only when idle |
| long_i | input | 1 | 1 = long branch, 0 = short branch |
| taken_i | input | 1 | 1 = branch taken |
| pre_odd_i | input | 1 | 1 = long-branch prefix byte on an odd address |
| seq_addr_i | input | AW | Next sequential program address |
| tgt_ready_i | input | 1 | Destination address valid |
| tgt_addr_i | input | AW | Destination address |
| cyc_type_o | output | 2 | 00 idle, 01 program fetch, 10 free cycle |
| fetch_addr_o | output | AW | Word address of the current fetch, zero otherwise |
| flush_o | output | 1 | Queue flush request before the refill |
| done_o | output | 1 | Sequence finished pulse |

## Verification
All outputs decode from registered state. The first result of a sequence therefore appears in the clock after the start edge, and each later entry follows exactly one clock after the one before it. The exception is the flush cycle, which lands in whichever idle cycle first sees the destination ready. The refill fetches follow the flush in the next three clocks, and done_o follows the last bus cycle by one clock. The driver knows the exact cycle in which it raises the ready input. It queues one expected entry per clock, including every waiting cycle and a trailing idle entry after done. The monitor pops one entry at each falling edge, half a period after the registers settle, so every comparison sits in the cycle its result is due.

// File: rtl/brq_pkg.sv
`timescale 1ns/1ps
package brq_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'b00,
      CYC_FETCH = 2'b01,
      CYC_FREE  = 2'b10
   } cyc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SEQF,
      ST_MAINT,
      ST_WAIT,
      ST_REFILL,
      ST_DONE
   } st_e;

endpackage

// File: rtl/brq_fsm.sv
`timescale 1ns/1ps
module brq_fsm
   import brq_pkg::*;
#(
   parameter int REFILL_WORDS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_long,
   input  logic taken,
   input  logic pre_odd,
   input  logic tgt_ready,
   output cyc_e cyc_type,
   output logic start_acc,
   output logic seq_step,
   output logic tgt_load,
   output logic tgt_step,
   output logic use_tgt,
   output logic done
);

   localparam int CW = (REFILL_WORDS > 1) ? $clog2(REFILL_WORDS) : 1;
   localparam logic [CW-1:0] LAST = CW'(REFILL_WORDS - 1);

   st_e           st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          long_q, taken_q, odd_q;

   always_comb begin
      st_d      = st_q;
      cnt_d     = cnt_q;
      cyc_type  = CYC_IDLE;
      start_acc = 1'b0;
      seq_step  = 1'b0;
      tgt_load  = 1'b0;
      tgt_step  = 1'b0;
      use_tgt   = 1'b0;
      done      = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               start_acc = 1'b1;
               if (is_long)    st_d = ST_PRE;
               else if (taken) st_d = ST_WAIT;
               else            st_d = ST_SEQF;
            end
         end
         ST_PRE: begin
            cyc_type = odd_q ? CYC_FETCH : CYC_FREE;
            seq_step = odd_q;
            st_d     = taken_q ? ST_WAIT : ST_SEQF;
         end
         ST_SEQF: begin
            cyc_type = CYC_FETCH;
            seq_step = 1'b1;
            st_d     = long_q ? ST_MAINT : ST_DONE;
         end
         ST_MAINT: begin
            cyc_type = odd_q ? CYC_FETCH : CYC_FREE;
            seq_step = odd_q;
            st_d     = ST_DONE;
         end
         ST_WAIT: begin
            if (tgt_ready) begin
               tgt_load = 1'b1;
               cnt_d    = '0;
               st_d     = ST_REFILL;
            end
         end
         ST_REFILL: begin
            cyc_type = CYC_FETCH;
            use_tgt  = 1'b1;
            tgt_step = 1'b1;
            if (cnt_q == LAST) st_d = ST_DONE;
            else               cnt_d = cnt_q + 1'b1;
         end
         ST_DONE: begin
            done = 1'b1;
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         long_q  <= 1'b0;
         taken_q <= 1'b0;
         odd_q   <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         if (start_acc) begin
            long_q  <= is_long;
            taken_q <= taken;
            odd_q   <= pre_odd;
         end
      end
   end

endmodule

// File: rtl/brq_addr_gen.sv
`timescale 1ns/1ps
module brq_addr_gen #(
   parameter int AW         = 16,
   parameter int WORD_BYTES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          seq_load,
   input  logic          seq_step,
   input  logic          tgt_load,
   input  logic          tgt_step,
   input  logic          use_tgt,
   input  logic [AW-1:0] seq_addr,
   input  logic [AW-1:0] tgt_addr,
   output logic [AW-1:0] addr
);

   localparam int LSB = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   logic [AW-1:0] seq_al, tgt_al;
   logic [AW-1:0] seq_q, tgt_q;

   generate
      if (LSB == 0) begin : g_byte
         assign seq_al = seq_addr;
         assign tgt_al = tgt_addr;
      end else begin : g_word
         assign seq_al = {seq_addr[AW-1:LSB], {LSB{1'b0}}};
         assign tgt_al = {tgt_addr[AW-1:LSB], {LSB{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q <= '0;
         tgt_q <= '0;
      end else begin
         if (seq_load)      seq_q <= seq_al;
         else if (seq_step) seq_q <= seq_q + STEP;
         if (tgt_load)      tgt_q <= tgt_al;
         else if (tgt_step) tgt_q <= tgt_q + STEP;
      end
   end

   assign addr = use_tgt ? tgt_q : seq_q;

endmodule

// File: rtl/brq_sequencer.sv
`timescale 1ns/1ps
module brq_sequencer
   import brq_pkg::*;
#(
   parameter int AW           = 16,
   parameter int WORD_BYTES   = 2,
   parameter int REFILL_WORDS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          long_i,
   input  logic          taken_i,
   input  logic          pre_odd_i,
   input  logic [AW-1:0] seq_addr_i,
   input  logic          tgt_ready_i,
   input  logic [AW-1:0] tgt_addr_i,
   output logic [1:0]    cyc_type_o,
   output logic [AW-1:0] fetch_addr_o,
   output logic          flush_o,
   output logic          done_o
);

   localparam int LSB = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

   generate
      if (AW < LSB + 2) begin : g_bad_aw
         $error("brq_sequencer: AW too small for WORD_BYTES");
      end
      if ((1 << LSB) != WORD_BYTES) begin : g_bad_wb
         $error("brq_sequencer: WORD_BYTES must be a power of two");
      end
      if (REFILL_WORDS < 1) begin : g_bad_rf
         $error("brq_sequencer: REFILL_WORDS must be at least one");
      end
   endgenerate

   cyc_e          cyc;
   logic          start_acc, seq_step, tgt_load, tgt_step, use_tgt, done;
   logic [AW-1:0] addr;

   brq_fsm #(.REFILL_WORDS(REFILL_WORDS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .is_long   (long_i),
      .taken     (taken_i),
      .pre_odd   (pre_odd_i),
      .tgt_ready (tgt_ready_i),
      .cyc_type  (cyc),
      .start_acc (start_acc),
      .seq_step  (seq_step),
      .tgt_load  (tgt_load),
      .tgt_step  (tgt_step),
      .use_tgt   (use_tgt),
      .done      (done)
   );

   brq_addr_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .seq_load (start_acc),
      .seq_step (seq_step),
      .tgt_load (tgt_load),
      .tgt_step (tgt_step),
      .use_tgt  (use_tgt),
      .seq_addr (seq_addr_i),
      .tgt_addr (tgt_addr_i),
      .addr     (addr)
   );

   assign cyc_type_o   = cyc;
   assign fetch_addr_o = (cyc == CYC_FETCH) ? addr : '0;
   assign flush_o      = tgt_load;
   assign done_o       = done;

endmodule

// File: rtl/brq_checker.sv
`timescale 1ns/1ps
module brq_checker #(
   parameter int AW         = 16,
   parameter int WORD_BYTES = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    cyc_type_o,
   input logic [AW-1:0] fetch_addr_o,
   input logic [AW-1:0] tgt_addr_i,
   input logic          flush_o,
   input logic          done_o
);

   localparam int LSB = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
   localparam logic [AW-1:0] MASK = ~AW'((1 << LSB) - 1);

   // R7: a flush is followed by the first refill fetch at the aligned destination
   a_r7_flush_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> (cyc_type_o == 2'b01) && (fetch_addr_o == ($past(tgt_addr_i) & MASK)));

   // R7: flush only while the bus is idle
   a_r7_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> cyc_type_o == 2'b00);

   // R8: done lasts one cycle and sits on an idle cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cyc_type_o == 2'b00) && !flush_o);

   // R3 / R5: back-to-back fetches step by one word
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc_type_o == 2'b01) && ($past(cyc_type_o) == 2'b01))
         |-> fetch_addr_o == $past(fetch_addr_o) + STEP);

   // R5: no address outside fetch cycles, and no reserved code
   a_r5_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type_o != 2'b01) |-> fetch_addr_o == '0);
   a_r5_legal_type: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_type_o != 2'b11);

endmodule

bind brq_sequencer brq_checker #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cyc_type_o   (cyc_type_o),
   .fetch_addr_o (fetch_addr_o),
   .tgt_addr_i   (tgt_addr_i),
   .flush_o      (flush_o),
   .done_o       (done_o)
);

// File: tb/tb_brq_sequencer.sv
`timescale 1ns/1ps
module tb_brq_sequencer;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0, long_i = 1'b0, taken_i = 1'b0, pre_odd_i = 1'b0;
   logic [AW-1:0] seq_addr_i = '0, tgt_addr_i = '0;
   logic          tgt_ready_i = 1'b0;
   logic [1:0]    cyc_type_o;
   logic [AW-1:0] fetch_addr_o;
   logic          flush_o, done_o;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   brq_sequencer #(.AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(long_i),
      .taken_i(taken_i), .pre_odd_i(pre_odd_i), .seq_addr_i(seq_addr_i),
      .tgt_ready_i(tgt_ready_i), .tgt_addr_i(tgt_addr_i),
      .cyc_type_o(cyc_type_o), .fetch_addr_o(fetch_addr_o),
      .flush_o(flush_o), .done_o(done_o)
   );

   always #2 clk = ~clk;

   typedef struct {
      logic [1:0]    ty;
      logic [AW-1:0] ad;
      logic          fl;
      logic          dn;
      string         rq;
   } exp_t;

   exp_t q[$];

   function automatic void push(logic [1:0] ty, logic [AW-1:0] ad, logic fl, logic dn, string rq);
      exp_t e;
      e.ty = ty; e.ad = ad; e.fl = fl; e.dn = dn; e.rq = rq;
      q.push_back(e);
   endfunction

   task automatic check_now(exp_t e);
      checks++;
      if (cyc_type_o !== e.ty || fetch_addr_o !== e.ad || flush_o !== e.fl || done_o !== e.dn) begin
         errors++;
         $display("FAIL %s: got type=%0d addr=%h flush=%0b done=%0b, expected type=%0d addr=%h flush=%0b done=%0b",
                  e.rq, cyc_type_o, fetch_addr_o, flush_o, done_o, e.ty, e.ad, e.fl, e.dn);
      end
   endtask

   // monitor: one expected entry per cycle, sampled at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) check_now(q.pop_front());
   end

   task automatic run_seq(input bit lng, input bit tkn, input bit odd,
                          input logic [AW-1:0] seq, input logic [AW-1:0] tgt,
                          input int dly, input bit poke, input string rq_main);
      logic [AW-1:0] s, t;
      int n, ws, base;
      string rq;
      s  = {seq[AW-1:1], 1'b0};
      t  = {tgt[AW-1:1], 1'b0};
      ws = lng ? 1 : 0;
      rq = poke ? "R10" : rq_main;
      @(negedge clk); #1;
      long_i = lng; taken_i = tkn; pre_odd_i = odd;
      seq_addr_i = seq; tgt_addr_i = tgt;
      tgt_ready_i = 1'b0; start_i = 1'b1;
      base = q.size();
      if (lng) begin
         push(odd ? 2'b01 : 2'b10, odd ? s : '0, 1'b0, 1'b0, poke ? rq : "R5");
         if (odd) s = s + 2;
      end
      if (tkn) begin
         for (int i = 0; i < dly; i++) push(2'b00, '0, 1'b0, 1'b0, rq);
         push(2'b00, '0, 1'b1, 1'b0, poke ? rq : "R7");
         for (int i = 0; i < 3; i++) push(2'b01, t + AW'(2 * i), 1'b0, 1'b0, rq);
      end else begin
         push(2'b01, s, 1'b0, 1'b0, rq);
         s = s + 2;
         if (lng) push(odd ? 2'b01 : 2'b10, odd ? s : '0, 1'b0, 1'b0, poke ? rq : "R5");
      end
      push(2'b00, '0, 1'b0, 1'b1, poke ? rq : "R8");
      push(2'b00, '0, 1'b0, 1'b0, poke ? "R9" : "R8");
      n = q.size() - base;
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         start_i = poke && (k == 0 || k == n - 2);
         if (poke && k == 0) begin
            long_i = ~lng; taken_i = ~tkn; pre_odd_i = ~odd;
            seq_addr_i = seq ^ 16'h0F00;
         end
         tgt_ready_i = tkn && (k >= ws + dly) && (k < n - 2);
      end
      @(negedge clk); #1;
      start_i = 1'b0; tgt_ready_i = 1'b0;
   endtask

   initial begin
      #200000;
      if (!ended) begin
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      exp_t r;
      r.ty = 2'b00; r.ad = '0; r.fl = 1'b0; r.dn = 1'b0; r.rq = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_now(r);                       // R1 during reset
      #1 rst_n = 1'b1;
      @(negedge clk);
      check_now(r);                       // R1 after reset
      run_seq(0, 0, 0, 16'h1234, 16'h0, 0, 0, "R2");   // R2 short not taken
      run_seq(0, 0, 1, 16'h2001, 16'h0, 0, 0, "R2");   // R2 odd seq address
      run_seq(0, 1, 0, 16'h1000, 16'h4000, 0, 0, "R3"); // R3 target ready at once
      run_seq(0, 1, 0, 16'h1000, 16'h4567, 2, 0, "R3"); // R3 two wait cycles
      run_seq(0, 1, 0, 16'h1000, 16'hFFFE, 1, 0, "R3"); // R3 wraparound
      run_seq(1, 0, 1, 16'h1001, 16'h0, 0, 0, "R4");   // R4 misaligned prefix
      run_seq(1, 0, 0, 16'h3000, 16'h0, 0, 0, "R4");   // R4/R5 aligned prefix
      run_seq(1, 1, 1, 16'h5000, 16'h6001, 1, 0, "R6"); // R6 misaligned prefix
      run_seq(1, 1, 0, 16'h5000, 16'h7000, 0, 0, "R6"); // R6 aligned prefix
      run_seq(0, 1, 0, 16'h1000, 16'h8000, 1, 1, "R9"); // R9/R10 busy start
      run_seq(1, 0, 1, 16'h2203, 16'h0, 0, 1, "R9");   // R9/R10 busy start
      run_seq(1, 1, 0, 16'h0040, 16'h9ABC, 0, 1, "R9"); // R9/R10 busy start
      repeat (3) @(posedge clk);
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule